// File: doc/BRIEF.md
# TRIM Range Checker

This block processes the payload of a data-set-management request whose feature byte selects TRIM. One payload holds a fixed number of 64-bit little-endian range entries packed back to back. The default is 512 bytes, which gives 64 entries.

For each entry the block splits out a starting LBA and a sector count. It checks the range against the device capacity that was captured when the command started. A range that fits is passed on as a discard request over a valid/ready port. A range that ends beyond the last sector aborts the command. No discard is issued for that entry or for any later one, but the remaining entries are still drained.

When the whole payload has been taken and the last discard has been handed over, the block pulses `done`. It then presents an ATA-style status byte and error byte. The DMA engine feeding the entries and the medium that performs the discards are outside the block.

Top module: `trim_range_checker`

## Requirements
- R1: Entry bits [47:0] give the starting LBA and bits [63:48] give the sector count. A valid range produces exactly one discard carrying that LBA and count, and discards appear in payload order.
- R2: A range is valid when LBA + count <= capacity. The sum is formed without overflow. Any range ending beyond sector capacity-1 aborts the command.
- R3: An entry with a count of zero produces no discard and never causes an abort, whatever its LBA.
- R4: After the first invalid range, no further discards are issued and the remaining entries are still accepted. Discards issued before it stand.
- R5: Once all payload entries have been accepted and no discard is pending, `done` is high for exactly one cycle. From that cycle on, status reads 0x40 and error reads 0x00 on success. On abort, status reads 0x41 and error reads 0x04. Status bit 7 means busy, bit 6 ready, bit 5 fault and bit 0 error; error bit 2 means abort.
- R6: While a command is active, status reads 0x80, and entries are accepted only then.
- R7: Capacity is sampled on the cycle the command starts. Later changes have no effect on that command.
- R8: A start with a feature byte other than 1 drains the payload, issues no discard and completes with abort.
- R9: A start pulse while a command is active is ignored.
- R10: A pending discard holds its LBA and count stable until it is taken. A new entry may be accepted in the same cycle a discard is taken.
- R11: After reset, status reads 0x40, error reads 0x00, and `ent_ready`, `dis_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_feature | input | 8 | Feature byte; 1 selects TRIM |
| capacity | input | 48 | Device capacity in sectors |
| ent_valid | input | 1 | Range entry valid |
| ent_ready | output | 1 | Range entry accepted this cycle when valid |
| ent_data | input | 64 | Range entry, count in high 16 bits, LBA in low 48 |
| dis_valid | output | 1 | Discard request valid |
| dis_ready | input | 1 | Discard sink ready |
| dis_lba | output | 48 | Discard starting LBA |
| dis_count | output | 16 | Discard sector count |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Status byte |
| error | output | 8 | Error byte |

## Verification
Two actions can land in the same clock edge: taking a pending discard and accepting the next range entry. The bench provokes this overlap by streaming a full payload of valid ranges with the discard sink always ready, and it counts the edges where both handshakes occur. The overlap is judged correct when the count is non-zero and every discard still matches the model in order and value. The same payload style is repeated with the sink throttled, to show that a held discard stays stable and blocks further entries.

// File: rtl/trim_range_checker.sv
module trim_range_checker #(
  parameter int LBA_W         = 48,
  parameter int CNT_W         = 16,
  parameter int PAYLOAD_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [7:0]       cmd_feature,
  input  logic [LBA_W-1:0] capacity,
  input  logic             ent_valid,
  output logic             ent_ready,
  input  logic [LBA_W+CNT_W-1:0] ent_data,
  output logic             dis_valid,
  input  logic             dis_ready,
  output logic [LBA_W-1:0] dis_lba,
  output logic [CNT_W-1:0] dis_count,
  output logic             done,
  output logic [7:0]       status,
  output logic [7:0]       error
);
  localparam int ENT_W   = LBA_W + CNT_W;
  localparam int ENTRIES = PAYLOAD_BYTES * 8 / ENT_W;
  localparam int IDX_W   = $clog2(ENTRIES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES);

  logic             busy_q, bad_q, err_q, done_q, pend_q;
  logic [IDX_W-1:0] taken_q;
  logic [LBA_W-1:0] cap_q, lba_q;
  logic [CNT_W-1:0] cnt_q;

  wire [LBA_W-1:0] e_lba  = ent_data[LBA_W-1:0];
  wire [CNT_W-1:0] e_cnt  = ent_data[ENT_W-1:LBA_W];
  wire [LBA_W:0]   e_end  = {1'b0, e_lba} + {{(LBA_W+1-CNT_W){1'b0}}, e_cnt};
  wire             e_fits = e_end <= {1'b0, cap_q};
  wire             e_zero = e_cnt == '0;

  assign ent_ready = busy_q && (taken_q != LAST) && (!pend_q || dis_ready);

  wire take    = ent_valid && ent_ready;
  wire e_issue = take && !bad_q && !e_zero && e_fits;
  wire e_fail  = take && !bad_q && !e_zero && !e_fits;
  wire finish  = busy_q && (taken_q == LAST) && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bad_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
      taken_q <= '0;
      cap_q   <= '0;
      lba_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= finish;
      if (!busy_q && cmd_start) begin
        busy_q  <= 1'b1;
        bad_q   <= cmd_feature != 8'd1;
        err_q   <= 1'b0;
        cap_q   <= capacity;
        taken_q <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= bad_q;
      end else begin
        if (take)   taken_q <= taken_q + 1'b1;
        if (e_fail) bad_q   <= 1'b1;
      end
      if (e_issue) begin
        pend_q <= 1'b1;
        lba_q  <= e_lba;
        cnt_q  <= e_cnt;
      end else if (pend_q && dis_ready) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign dis_valid = pend_q;
  assign dis_lba   = lba_q;
  assign dis_count = cnt_q;
  assign done      = done_q;
  assign status    = {busy_q, !busy_q, 1'b0, 4'b0, err_q};
  assign error     = {5'b0, err_q, 2'b0};
endmodule

// File: rtl/trim_range_checker_sva.sv
module trim_range_checker_sva #(
  parameter int LBA_W = 48,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ent_valid,
  input logic             ent_ready,
  input logic             dis_valid,
  input logic             dis_ready,
  input logic [LBA_W-1:0] dis_lba,
  input logic [CNT_W-1:0] dis_count,
  input logic             done,
  input logic [7:0]       status,
  input logic [LBA_W-1:0] cap_q,
  input logic             bad_q
);
  wire [LBA_W:0] d_end = {1'b0, dis_lba} + {{(LBA_W+1-CNT_W){1'b0}}, dis_count};

  assert_hold_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_valid && !dis_ready |=> dis_valid && $stable(dis_lba) && $stable(dis_count));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dis_valid && !status[7]);

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> status[7]);

  assert_in_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_valid |-> d_end <= {1'b0, cap_q});

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_valid |-> dis_count != '0);

  assert_no_issue_after_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q && ent_valid && ent_ready |=> !dis_valid);
endmodule

bind trim_range_checker trim_range_checker_sva #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
  .dis_valid(dis_valid), .dis_ready(dis_ready), .dis_lba(dis_lba),
  .dis_count(dis_count), .done(done), .status(status), .cap_q(cap_q), .bad_q(bad_q)
);

// File: tb/tb_trim_range_checker.sv
module tb_trim_range_checker;
  localparam int N = 64;

  logic        clk = 0, rst_n = 0;
  logic        cmd_start = 0;
  logic [7:0]  cmd_feature = 0;
  logic [47:0] capacity = 0;
  logic        ent_valid = 0, ent_ready;
  logic [63:0] ent_data = 0;
  logic        dis_valid, dis_ready;
  logic [47:0] dis_lba;
  logic [15:0] dis_count;
  logic        done;
  logic [7:0]  status, error;

  trim_range_checker dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit bp = 0;
  always @(posedge clk) begin
    #2;
    cyc++;
    dis_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  logic [47:0] e_lba [N];
  logic [15:0] e_cnt [N];
  logic [47:0] g_lba [N];
  logic [15:0] g_cnt [N];
  logic [47:0] x_lba [N];
  logic [15:0] x_cnt [N];
  int n_got, n_exp, done_cnt, overlap;
  bit exp_err, busy_seen;
  logic [7:0] st_cap, er_cap;

  always @(negedge clk) begin
    if (dis_valid && dis_ready) begin
      if (n_got < N) begin g_lba[n_got] = dis_lba; g_cnt[n_got] = dis_count; end
      n_got++;
    end
    if (dis_valid && dis_ready && ent_valid && ent_ready) overlap++;
    if (done) begin done_cnt++; st_cap = status; er_cap = error; end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin e_lba[i] = 0; e_cnt[i] = 0; end
  endtask

  task automatic model(input logic [7:0] feat, input logic [47:0] cap);
    bit bad;
    bad = (feat != 8'd1);
    n_exp = 0;
    for (int i = 0; i < N; i++) begin
      if (!bad && e_cnt[i] != 0) begin
        if ({1'b0, e_lba[i]} + {33'b0, e_cnt[i]} > {1'b0, cap}) bad = 1;
        else begin x_lba[n_exp] = e_lba[i]; x_cnt[n_exp] = e_cnt[i]; n_exp++; end
      end
    end
    exp_err = bad;
  endtask

  task automatic run_cmd(input logic [7:0] feat, input logic [47:0] cap,
                         input logic [47:0] cap_after, input bit restart);
    n_got = 0; done_cnt = 0; overlap = 0; busy_seen = 0;
    @(posedge clk); #2;
    cmd_start = 1; cmd_feature = feat; capacity = cap;
    @(posedge clk); #2;
    cmd_start = 0; capacity = cap_after;
    @(negedge clk);
    busy_seen = (status == 8'h80);
    @(posedge clk); #2;
    for (int i = 0; i < N; i++) begin
      if (restart && i == 5) begin cmd_start = 1; cmd_feature = 8'd3; capacity = 0; end
      ent_valid = 1; ent_data = {e_cnt[i], e_lba[i]};
      @(negedge clk);
      while (!ent_ready) @(negedge clk);
      @(posedge clk); #2;
      ent_valid = 0; cmd_start = 0;
    end
    for (int k = 0; k < 2000 && done_cnt == 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic check_cmd(input string req, input logic [7:0] feat, input logic [47:0] cap);
    model(feat, cap);
    check(done_cnt == 1, "R5", done_cnt, 1);
    check(busy_seen, "R6", busy_seen, 1);
    check(n_got == n_exp, {req, " R1"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(g_lba[i] == x_lba[i], {req, " R1 lba"}, g_lba[i], x_lba[i]);
      check(g_cnt[i] == x_cnt[i], {req, " R1 count"}, g_cnt[i], x_cnt[i]);
    end
    check(st_cap == (exp_err ? 8'h41 : 8'h40), {req, " R5 status"}, st_cap, exp_err ? 8'h41 : 8'h40);
    check(er_cap == (exp_err ? 8'h04 : 8'h00), {req, " R5 error"}, er_cap, exp_err ? 8'h04 : 8'h00);
  endtask

  // {lba, count, capacity, expect_abort}
  localparam logic [112:0] VEC [8] = '{
    {48'd0,            16'd2,      48'd1000,         1'b0},
    {48'd998,          16'd2,      48'd1000,         1'b0},
    {48'd999,          16'd2,      48'd1000,         1'b1},
    {48'd1000,         16'd1,      48'd1000,         1'b1},
    {48'd0,            16'd1000,   48'd1000,         1'b0},
    {48'hFFFFFFFFFFFF, 16'hFFFF,   48'hFFFFFFFFFFFF, 1'b1},
    {48'd500,          16'd0,      48'd100,          1'b0},
    {48'd10,           16'd1,      48'd11,           1'b0}
  };

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(status == 8'h40 && error == 8'h00, "R11 status/error", {status, error}, 16'h4000);
    check(!ent_ready && !dis_valid && !done, "R11 handshakes", {ent_ready, dis_valid, done}, 0);
    @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    check(status == 8'h40 && !ent_ready, "R11 after release", status, 8'h40);

    for (int v = 0; v < 8; v++) begin
      clear_entries();
      e_lba[0] = VEC[v][112:65]; e_cnt[0] = VEC[v][64:49];
      run_cmd(8'd1, VEC[v][48:1], VEC[v][48:1], 0);
      check_cmd("R2 table", 8'd1, VEC[v][48:1]);
      check(st_cap[0] == VEC[v][0], (v == 6) ? "R3 zero count" : "R2 bound", st_cap[0], VEC[v][0]);
    end

    clear_entries();
    for (int i = 0; i < N; i++) begin e_lba[i] = 48'(i * 100); e_cnt[i] = 16'(i + 1); end
    bp = 0;
    run_cmd(8'd1, 48'd1000000, 48'd1000000, 0);
    check_cmd("R10 stream", 8'd1, 48'd1000000);
    check(overlap > 0, "R10 same-cycle take", overlap, 1);

    bp = 1;
    run_cmd(8'd1, 48'd1000000, 48'd1000000, 0);
    check_cmd("R10 throttled", 8'd1, 48'd1000000);

    clear_entries();
    for (int i = 0; i < 10; i++) begin e_lba[i] = 48'(i * 10); e_cnt[i] = 16'd5; end
    e_lba[4] = 48'd995; e_cnt[4] = 16'd10;
    run_cmd(8'd1, 48'd1000, 48'd1000, 0);
    check_cmd("R4 first invalid", 8'd1, 48'd1000);
    check(n_got == 4, "R4 discards kept", n_got, 4);
    bp = 0;

    clear_entries();
    e_lba[0] = 48'd90; e_cnt[0] = 16'd10;
    e_lba[1] = 48'd150; e_cnt[1] = 16'd5;
    run_cmd(8'd1, 48'd100, 48'd1000, 0);
    check_cmd("R7 capacity latch", 8'd1, 48'd100);
    check(n_got == 1 && st_cap == 8'h41, "R7 later capacity ignored", n_got, 1);

    clear_entries();
    e_lba[0] = 48'd1; e_cnt[0] = 16'd1;
    run_cmd(8'd3, 48'd1000, 48'd1000, 0);
    check_cmd("R8 other feature", 8'd3, 48'd1000);
    check(n_got == 0, "R8 no discard", n_got, 0);

    clear_entries();
    for (int i = 0; i < 8; i++) begin e_lba[i] = 48'(i); e_cnt[i] = 16'd1; end
    run_cmd(8'd1, 48'd1000, 48'd1000, 1);
    check_cmd("R9 restart ignored", 8'd1, 48'd1000);
    check(n_got == 8 && st_cap == 8'h40, "R9 outcome", n_got, 8);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule